// File: doc/BRIEF.md
# Overlay Window Shadow Register Bank

The block holds the configuration of a set of overlay windows (five by default) in two copies. Software writes a staging copy through a one-word-per-cycle write port. The display pipeline sees only the shadow copy. A window's staging copy moves into its shadow copy on a vsync pulse, so a half-written setup never reaches the screen in the middle of a frame. One shared control word holds a DMA channel enable bit and a protect bit for each window. While a window is protected, vsync leaves its shadow copy alone, which lets software rewrite several registers of that window safely.

Each window has its own small state machine with three states. `ST_SYNC` means the shadow matches the staging copy. `ST_STAGED` means the staging copy has changed and the window waits for vsync. `ST_HELD` means the window is protected. The transitions are as follows:
- Sync to staged: on a write or a disable aimed at the window.
- Staged to sync: on a vsync in a cycle with no new write to the window. The copy is taken in that cycle.
- Any state to held: on a shared-word write that sets the window's protect bit.
- Held to staged: on a shared-word write that clears the protect bit.
- Any state to sync: on a clear of the window. Clear has priority over everything else.

Windows differ in which registers they have. Window 0 has no alpha register and no color-key registers. Only windows 0, 1 and 2 have an area register. A window can be disabled by a command that drops its enable bit and its channel enable together. A window can be cleared by a command that zeroes all of its registers.

Top module: `shadow_window_bank`

## Requirements
- R1: After reset, every staging and shadow register, every protect bit and every channel enable bit is zero.
- R2: A write to a window register changes only the staging copy. The change shows on `rd_data` (which always returns staging values) in the cycle after the write edge. The shadow outputs do not change until a vsync.
- R3: A vsync sampled on a clock edge while a window's protect bit is zero makes every shadow output of that window equal its staging values as they were before that edge. The new values are visible just after that edge.
- R4: While a window's protect bit is set, vsync leaves its shadow outputs unchanged. Writes to that window still land in the staging copy.
- R5: If a shared-word write clears a protect bit on the same edge as a vsync, that window is not copied on that edge. It is copied on the next vsync.
- R6: The shared word is selected with code 7, and the window index is ignored for it. Bits [NUM_WIN-1:0] are the channel enables and drive `chan_en` from the next cycle. Bits [2*NUM_WIN-1:NUM_WIN] are the protect bits.
- R7: Window 0 has no alpha, key-control or key-value register. Windows 3 and 4 have no area register. Writes to an absent register are ignored, and both its read value and its shadow output stay zero.
- R8: The alpha register holds three 4-bit opacity fields: red in [11:8], green in [7:4] and blue in [3:0]. The value 0xF means fully opaque. Bits above bit 11 read as zero.
- R9: A disable command clears the window's staging enable bit (control bit 0) and its channel enable bit on the next edge. The shadow enable bit follows at the next unprotected vsync.
- R10: A clear command zeroes the staging and shadow copies of the window and its protect bit on the next edge. Channel enables are left unchanged.
- R11: Both position registers hold X in bits [COORD_W-1:0] and Y in bits [16+COORD_W-1:16]. The bottom-right corner is inclusive, so it equals the top-left corner plus the size minus one. It is stored exactly as written, and other bits read as zero.
- R12: The select codes are: 0 control, 1 top-left, 2 bottom-right, 3 area, 4 alpha, 5 key control, 6 key value, 7 shared word. A write to a window index of NUM_WIN or above is ignored, and a read from such an index returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vsync | input | 1 | One-cycle frame-sync pulse |
| wr_en | input | 1 | Register write strobe |
| wr_win | input | WIN_IDX_W | Target window of the write |
| wr_sel | input | 3 | Register select code of the write |
| wr_data | input | 32 | Write data |
| rd_win | input | WIN_IDX_W | Window to read |
| rd_sel | input | 3 | Register select code to read |
| rd_data | output | 32 | Staging value or shared word (combinational) |
| dis_en | input | 1 | Disable-window command |
| dis_win | input | WIN_IDX_W | Window to disable |
| clr_en | input | 1 | Clear-window command |
| clr_win | input | WIN_IDX_W | Window to clear |
| chan_en | output | NUM_WIN | DMA channel enables |
| shd_ctrl | output | NUM_WIN*CTRL_W | Shadow control, per window |
| shd_tl | output | NUM_WIN*2*COORD_W | Shadow top-left {Y,X}, per window |
| shd_br | output | NUM_WIN*2*COORD_W | Shadow bottom-right {Y,X}, per window |
| shd_area | output | NUM_WIN*AREA_W | Shadow area size, per window |
| shd_alpha | output | NUM_WIN*12 | Shadow alpha, per window |
| shd_kctl | output | NUM_WIN*32 | Shadow key control, per window |
| shd_kval | output | NUM_WIN*32 | Shadow key value, per window |

## Verification
The bench builds the bank with five windows, an 8-bit control register, 11-bit coordinates and a 24-bit area field. With five windows, both presence boundaries come into play: window 0 has no alpha or key registers, and windows 3 and 4 have no area register. A 3-bit window index makes out-of-range indices 5 to 7 reachable. The 11-bit coordinates leave unused bits inside each 16-bit half, where masking can be observed. A behavioural model, compared on every clock, follows random mixes of writes, protects, vsyncs, disables and clears, including same-edge collisions.

// File: rtl/shadow_bank_pkg.sv
package shadow_bank_pkg;
    localparam int REG_W   = 32;
    localparam int ALPHA_W = 12;
    localparam int Y_LSB   = 16;

    typedef enum logic [2:0] {
        SEL_CTRL   = 3'd0,
        SEL_TL     = 3'd1,
        SEL_BR     = 3'd2,
        SEL_AREA   = 3'd3,
        SEL_ALPHA  = 3'd4,
        SEL_KCTL   = 3'd5,
        SEL_KVAL   = 3'd6,
        SEL_SHARED = 3'd7
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_SYNC   = 2'd0,
        ST_STAGED = 2'd1,
        ST_HELD   = 2'd2
    } win_state_e;
endpackage

// File: rtl/shadow_win_fsm.sv
module shadow_win_fsm
    import shadow_bank_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic vsync_i,
    input  logic touch_i,
    input  logic clr_i,
    input  logic prot_wr_i,
    input  logic prot_val_i,
    output logic held_o,
    output logic load_o
);
    win_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SYNC;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (clr_i) begin
            state_d = ST_SYNC;
        end else if (prot_wr_i && prot_val_i) begin
            state_d = ST_HELD;
        end else begin
            unique case (state_q)
                ST_SYNC:   if (touch_i) state_d = ST_STAGED;
                ST_STAGED: if (vsync_i && !touch_i) state_d = ST_SYNC;
                ST_HELD:   if (prot_wr_i) state_d = ST_STAGED;
                default:   state_d = ST_SYNC;
            endcase
        end
    end

    always_comb begin
        held_o = (state_q == ST_HELD);
        load_o = (state_q == ST_STAGED) && vsync_i && !clr_i;
    end

    // Same-edge protect release and vsync: no copy, wait in staged (R5)
    assert_release_waits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HELD && prot_wr_i && !prot_val_i && !clr_i) |=> (state_q == ST_STAGED));

    assert_clear_resyncs_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (state_q == ST_SYNC));
endmodule

// File: rtl/shadow_win_regs.sv
module shadow_win_regs
    import shadow_bank_pkg::*;
#(
    parameter int WIN_IDX = 0,
    parameter int CTRL_W  = 8,
    parameter int COORD_W = 11,
    parameter int AREA_W  = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_hit_i,
    input  reg_sel_e             wr_sel_i,
    input  logic [REG_W-1:0]     wr_data_i,
    input  logic                 dis_i,
    input  logic                 clr_i,
    input  logic                 load_i,
    input  logic                 held_i,
    input  reg_sel_e             rd_sel_i,
    output logic [REG_W-1:0]     rd_val_o,
    output logic [CTRL_W-1:0]    shd_ctrl_o,
    output logic [2*COORD_W-1:0] shd_tl_o,
    output logic [2*COORD_W-1:0] shd_br_o,
    output logic [AREA_W-1:0]    shd_area_o,
    output logic [ALPHA_W-1:0]   shd_alpha_o,
    output logic [REG_W-1:0]     shd_kctl_o,
    output logic [REG_W-1:0]     shd_kval_o
);
    localparam bit HAS_FX   = (WIN_IDX != 0);
    localparam bit HAS_AREA = (WIN_IDX < 3);
    localparam int POS_W    = 2 * COORD_W;

    logic [CTRL_W-1:0]  stg_ctrl, ctrl_d;
    logic [POS_W-1:0]   stg_tl, stg_br;
    logic [AREA_W-1:0]  stg_area;
    logic [ALPHA_W-1:0] stg_alpha;
    logic [REG_W-1:0]   stg_kctl, stg_kval;
    logic [POS_W-1:0]   wr_pos;

    assign wr_pos = {wr_data_i[Y_LSB +: COORD_W], wr_data_i[0 +: COORD_W]};

    always_comb begin
        ctrl_d = stg_ctrl;
        if (wr_hit_i && wr_sel_i == SEL_CTRL) ctrl_d = wr_data_i[CTRL_W-1:0];
        if (dis_i) ctrl_d[0] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_ctrl <= '0; stg_tl <= '0; stg_br <= '0;
            shd_ctrl_o <= '0; shd_tl_o <= '0; shd_br_o <= '0;
        end else if (clr_i) begin
            stg_ctrl <= '0; stg_tl <= '0; stg_br <= '0;
            shd_ctrl_o <= '0; shd_tl_o <= '0; shd_br_o <= '0;
        end else begin
            if (load_i) begin
                shd_ctrl_o <= stg_ctrl;
                shd_tl_o   <= stg_tl;
                shd_br_o   <= stg_br;
            end
            stg_ctrl <= ctrl_d;
            if (wr_hit_i && wr_sel_i == SEL_TL) stg_tl <= wr_pos;
            if (wr_hit_i && wr_sel_i == SEL_BR) stg_br <= wr_pos;
        end
    end

    generate
        if (HAS_AREA) begin : g_area
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n || clr_i) begin
                    stg_area <= '0; shd_area_o <= '0;
                end else begin
                    if (load_i) shd_area_o <= stg_area;
                    if (wr_hit_i && wr_sel_i == SEL_AREA) stg_area <= wr_data_i[AREA_W-1:0];
                end
            end
        end else begin : g_no_area
            assign stg_area   = '0;
            assign shd_area_o = '0;
        end

        if (HAS_FX) begin : g_fx
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n || clr_i) begin
                    stg_alpha <= '0; stg_kctl <= '0; stg_kval <= '0;
                    shd_alpha_o <= '0; shd_kctl_o <= '0; shd_kval_o <= '0;
                end else begin
                    if (load_i) begin
                        shd_alpha_o <= stg_alpha;
                        shd_kctl_o  <= stg_kctl;
                        shd_kval_o  <= stg_kval;
                    end
                    if (wr_hit_i && wr_sel_i == SEL_ALPHA) stg_alpha <= wr_data_i[ALPHA_W-1:0];
                    if (wr_hit_i && wr_sel_i == SEL_KCTL)  stg_kctl  <= wr_data_i;
                    if (wr_hit_i && wr_sel_i == SEL_KVAL)  stg_kval  <= wr_data_i;
                end
            end
        end else begin : g_no_fx
            assign stg_alpha   = '0;
            assign stg_kctl    = '0;
            assign stg_kval    = '0;
            assign shd_alpha_o = '0;
            assign shd_kctl_o  = '0;
            assign shd_kval_o  = '0;
        end
    endgenerate

    always_comb begin
        rd_val_o = '0;
        unique case (rd_sel_i)
            SEL_CTRL:  rd_val_o[CTRL_W-1:0] = stg_ctrl;
            SEL_TL: begin
                rd_val_o[0 +: COORD_W]     = stg_tl[COORD_W-1:0];
                rd_val_o[Y_LSB +: COORD_W] = stg_tl[POS_W-1:COORD_W];
            end
            SEL_BR: begin
                rd_val_o[0 +: COORD_W]     = stg_br[COORD_W-1:0];
                rd_val_o[Y_LSB +: COORD_W] = stg_br[POS_W-1:COORD_W];
            end
            SEL_AREA:  rd_val_o[AREA_W-1:0]  = stg_area;
            SEL_ALPHA: rd_val_o[ALPHA_W-1:0] = stg_alpha;
            SEL_KCTL:  rd_val_o = stg_kctl;
            SEL_KVAL:  rd_val_o = stg_kval;
            default:   rd_val_o = '0;
        endcase
    end

    // A protected window keeps its shadow through vsync, including a same-edge release (R5)
    assert_hold_shadow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (held_i && !clr_i) |=> ($stable(shd_ctrl_o) && $stable(shd_tl_o) && $stable(shd_br_o)));

    assert_no_early_copy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !clr_i) |=> ($stable(shd_ctrl_o) && $stable(shd_br_o) && $stable(shd_alpha_o)));

    assert_clear_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (stg_ctrl == '0 && shd_ctrl_o == '0 && stg_tl == '0 && shd_br_o == '0));
endmodule

// File: rtl/shadow_window_bank.sv
module shadow_window_bank
    import shadow_bank_pkg::*;
#(
    parameter  int NUM_WIN   = 5,
    parameter  int CTRL_W    = 8,
    parameter  int COORD_W   = 11,
    parameter  int AREA_W    = 24,
    localparam int WIN_IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           vsync,
    input  logic                           wr_en,
    input  logic [WIN_IDX_W-1:0]           wr_win,
    input  logic [2:0]                     wr_sel,
    input  logic [31:0]                    wr_data,
    input  logic [WIN_IDX_W-1:0]           rd_win,
    input  logic [2:0]                     rd_sel,
    output logic [31:0]                    rd_data,
    input  logic                           dis_en,
    input  logic [WIN_IDX_W-1:0]           dis_win,
    input  logic                           clr_en,
    input  logic [WIN_IDX_W-1:0]           clr_win,
    output logic [NUM_WIN-1:0]             chan_en,
    output logic [NUM_WIN*CTRL_W-1:0]      shd_ctrl,
    output logic [NUM_WIN*2*COORD_W-1:0]   shd_tl,
    output logic [NUM_WIN*2*COORD_W-1:0]   shd_br,
    output logic [NUM_WIN*AREA_W-1:0]      shd_area,
    output logic [NUM_WIN*12-1:0]          shd_alpha,
    output logic [NUM_WIN*32-1:0]          shd_kctl,
    output logic [NUM_WIN*32-1:0]          shd_kval
);
    localparam int POS_W = 2 * COORD_W;

    reg_sel_e               wsel, rsel;
    logic                   shared_wr;
    logic [NUM_WIN-1:0]     held, chan_d;
    logic [REG_W-1:0]       rd_vals [NUM_WIN];

    assign wsel      = reg_sel_e'(wr_sel);
    assign rsel      = reg_sel_e'(rd_sel);
    assign shared_wr = wr_en && (wsel == SEL_SHARED);

    always_comb begin
        chan_d = chan_en;
        if (shared_wr) chan_d = wr_data[NUM_WIN-1:0];
        for (int i = 0; i < NUM_WIN; i++) begin
            if (dis_en && int'(dis_win) == i) chan_d[i] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chan_en <= '0;
        else        chan_en <= chan_d;
    end

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        logic wr_hit, dis_hit, clr_hit, load;

        assign wr_hit  = wr_en && !shared_wr && (int'(wr_win) == w);
        assign dis_hit = dis_en && (int'(dis_win) == w);
        assign clr_hit = clr_en && (int'(clr_win) == w);

        shadow_win_fsm u_fsm (
            .clk        (clk),
            .rst_n      (rst_n),
            .vsync_i    (vsync),
            .touch_i    (wr_hit || dis_hit),
            .clr_i      (clr_hit),
            .prot_wr_i  (shared_wr),
            .prot_val_i (wr_data[NUM_WIN + w]),
            .held_o     (held[w]),
            .load_o     (load)
        );

        shadow_win_regs #(
            .WIN_IDX (w),
            .CTRL_W  (CTRL_W),
            .COORD_W (COORD_W),
            .AREA_W  (AREA_W)
        ) u_regs (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_hit_i    (wr_hit),
            .wr_sel_i    (wsel),
            .wr_data_i   (wr_data),
            .dis_i       (dis_hit),
            .clr_i       (clr_hit),
            .load_i      (load),
            .held_i      (held[w]),
            .rd_sel_i    (rsel),
            .rd_val_o    (rd_vals[w]),
            .shd_ctrl_o  (shd_ctrl[w*CTRL_W +: CTRL_W]),
            .shd_tl_o    (shd_tl[w*POS_W +: POS_W]),
            .shd_br_o    (shd_br[w*POS_W +: POS_W]),
            .shd_area_o  (shd_area[w*AREA_W +: AREA_W]),
            .shd_alpha_o (shd_alpha[w*ALPHA_W +: ALPHA_W]),
            .shd_kctl_o  (shd_kctl[w*REG_W +: REG_W]),
            .shd_kval_o  (shd_kval[w*REG_W +: REG_W])
        );
    end

    always_comb begin
        rd_data = '0;
        if (rsel == SEL_SHARED)            rd_data[2*NUM_WIN-1:0] = {held, chan_en};
        else if (int'(rd_win) < NUM_WIN)   rd_data = rd_vals[rd_win];
    end

    assert_absent_fx_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_win == '0 && (rsel == SEL_ALPHA || rsel == SEL_KCTL || rsel == SEL_KVAL)) |-> (rd_data == '0));

    assert_disable_chan_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_en && int'(dis_win) < NUM_WIN) |=> !chan_en[$past(dis_win)]);

    assert_bad_index_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rd_win) >= NUM_WIN && rsel != SEL_SHARED) |-> (rd_data == '0));
endmodule

// File: tb/shadow_window_bank_bench.sv
`timescale 1ns/1ps
module shadow_window_bank_bench;
    localparam int NW = 5;
    localparam int CW = 8;
    localparam int XW = 11;
    localparam int AW = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vsync = 1'b0, wr_en = 1'b0, dis_en = 1'b0, clr_en = 1'b0;
    logic [2:0]  wr_win = '0, rd_win = '0, dis_win = '0, clr_win = '0;
    logic [2:0]  wr_sel = '0, rd_sel = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [NW-1:0]       chan_en;
    logic [NW*CW-1:0]    shd_ctrl;
    logic [NW*2*XW-1:0]  shd_tl, shd_br;
    logic [NW*AW-1:0]    shd_area;
    logic [NW*12-1:0]    shd_alpha;
    logic [NW*32-1:0]    shd_kctl, shd_kval;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_stg [NW][7];
    logic [31:0] m_shd [NW][7];
    logic [NW-1:0] m_prot, m_chan;

    always #2.5 clk = ~clk;

    shadow_window_bank #(.NUM_WIN(NW), .CTRL_W(CW), .COORD_W(XW), .AREA_W(AW)) u_shadow_window_bank (
        .clk(clk), .rst_n(rst_n), .vsync(vsync), .wr_en(wr_en), .wr_win(wr_win), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_win(rd_win), .rd_sel(rd_sel), .rd_data(rd_data), .dis_en(dis_en),
        .dis_win(dis_win), .clr_en(clr_en), .clr_win(clr_win), .chan_en(chan_en), .shd_ctrl(shd_ctrl),
        .shd_tl(shd_tl), .shd_br(shd_br), .shd_area(shd_area), .shd_alpha(shd_alpha),
        .shd_kctl(shd_kctl), .shd_kval(shd_kval)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] mask_val(input int w, input int sel, input logic [31:0] d);
        case (sel)
            0:       return d & 32'h0000_00FF;
            1, 2:    return d & 32'h07FF_07FF;
            3:       return (w < 3) ? (d & 32'h00FF_FFFF) : 32'h0;
            4:       return (w != 0) ? (d & 32'h0000_0FFF) : 32'h0;
            5, 6:    return (w != 0) ? d : 32'h0;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] m_read(input int w, input int sel);
        if (sel == 7) return {22'h0, m_prot, m_chan};
        if (w >= NW) return 32'h0;
        return m_stg[w][sel];
    endfunction

    task automatic model_step();
        logic [31:0] o_stg [NW][7];
        logic [NW-1:0] o_prot;
        o_stg = m_stg;
        o_prot = m_prot;
        for (int w = 0; w < NW; w++)
            if (vsync && !o_prot[w]) for (int s = 0; s < 7; s++) m_shd[w][s] = o_stg[w][s];
        if (wr_en) begin
            if (wr_sel == 3'd7) begin
                m_chan = wr_data[NW-1:0];
                m_prot = wr_data[2*NW-1:NW];
            end else if (int'(wr_win) < NW) begin
                m_stg[wr_win][wr_sel] = mask_val(int'(wr_win), int'(wr_sel), wr_data);
            end
        end
        if (dis_en && int'(dis_win) < NW) begin
            m_stg[dis_win][0][0] = 1'b0;
            m_chan[dis_win] = 1'b0;
        end
        if (clr_en && int'(clr_win) < NW) begin
            for (int s = 0; s < 7; s++) begin
                m_stg[clr_win][s] = '0;
                m_shd[clr_win][s] = '0;
            end
            m_prot[clr_win] = 1'b0;
        end
    endtask

    task automatic compare_all();
        for (int w = 0; w < NW; w++) begin
            chk("R3 shadow ctrl", 32'(shd_ctrl[w*CW +: CW]), m_shd[w][0]);
            chk("R11 shadow top-left", 32'(shd_tl[w*2*XW +: 2*XW]),
                32'({m_shd[w][1][16 +: XW], m_shd[w][1][0 +: XW]}));
            chk("R11 shadow bottom-right", 32'(shd_br[w*2*XW +: 2*XW]),
                32'({m_shd[w][2][16 +: XW], m_shd[w][2][0 +: XW]}));
            chk("R7 shadow area", 32'(shd_area[w*AW +: AW]), m_shd[w][3]);
            chk("R8 shadow alpha", 32'(shd_alpha[w*12 +: 12]), m_shd[w][4]);
            chk("R7 shadow key ctl", shd_kctl[w*32 +: 32], m_shd[w][5]);
            chk("R7 shadow key val", shd_kval[w*32 +: 32], m_shd[w][6]);
        end
        chk("R6 channel enables", 32'(chan_en), 32'(m_chan));
        chk("R2 read staging", rd_data, m_read(int'(rd_win), int'(rd_sel)));
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic wr(input int w, input int sel, input logic [31:0] d);
        wr_en = 1'b1; wr_win = 3'(w); wr_sel = 3'(sel); wr_data = d;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic vs();
        vsync = 1'b1; cyc(); vsync = 1'b0;
    endtask

    task automatic rd(input int w, input int sel);
        rd_win = 3'(w); rd_sel = 3'(sel); #0.1;
    endtask

    initial begin
        #(200000.0 * 5.0);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int w = 0; w < NW; w++)
            for (int s = 0; s < 7; s++) begin m_stg[w][s] = '0; m_shd[w][s] = '0; end
        m_prot = '0; m_chan = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        rd(0, 7);
        chk("R1 shared word after reset", rd_data, 32'h0);
        chk("R1 shadow ctrl after reset", 32'(shd_ctrl), 32'h0);
        chk("R1 chan after reset", 32'(chan_en), 32'h0);

        // R2 / R3 / R11: staging then vsync
        wr(1, 0, 32'h0000_0105);
        wr(1, 1, 32'h0010_0020);
        wr(1, 2, 32'hF82F_F8FF);
        rd(1, 0);
        chk("R2 staged ctrl readback", rd_data, 32'h05);
        chk("R2 shadow ctrl unchanged", 32'(shd_ctrl[1*CW +: CW]), 32'h0);
        rd(1, 2);
        chk("R11 bottom-right masked", rd_data, 32'h002F_00FF);
        vs();
        chk("R3 shadow ctrl after vsync", 32'(shd_ctrl[1*CW +: CW]), 32'h05);
        chk("R11 shadow bottom-right", 32'(shd_br[1*2*XW +: 2*XW]), 32'((32'h2F << XW) | 32'hFF));

        // R4 protect
        wr(0, 7, 32'h0000_0084);
        wr(2, 0, 32'h0000_0003);
        vs();
        chk("R4 protected shadow held", 32'(shd_ctrl[2*CW +: CW]), 32'h0);
        rd(2, 0);
        chk("R4 staging accepts write", rd_data, 32'h3);
        rd(3, 7);
        chk("R6 shared readback", rd_data, 32'h84);
        chk("R6 chan bit 2", 32'(chan_en), 32'h04);

        // R5 same-edge release
        vsync = 1'b1;
        wr(0, 7, 32'h0000_0004);
        vsync = 1'b0;
        chk("R5 no copy on release edge", 32'(shd_ctrl[2*CW +: CW]), 32'h0);
        vs();
        chk("R5 copy on next vsync", 32'(shd_ctrl[2*CW +: CW]), 32'h3);

        // R7 / R8 absent and alpha
        wr(0, 4, 32'h0000_0FFF);
        wr(0, 6, 32'h1234_5678);
        wr(3, 3, 32'h0000_1234);
        wr(1, 4, 32'h0000_ABCD);
        rd(0, 4);
        chk("R7 window0 alpha absent", rd_data, 32'h0);
        rd(0, 6);
        chk("R7 window0 key absent", rd_data, 32'h0);
        rd(3, 3);
        chk("R7 window3 area absent", rd_data, 32'h0);
        rd(1, 4);
        chk("R8 alpha fields", rd_data, 32'h0000_0BCD);
        vs();
        chk("R8 shadow alpha", 32'(shd_alpha[1*12 +: 12]), 32'h0BCD);
        chk("R7 window0 shadow alpha", 32'(shd_alpha[0 +: 12]), 32'h0);

        // R9 disable
        wr(0, 7, 32'h0000_001F);
        wr(1, 0, 32'h0000_00FF);
        vs();
        dis_en = 1'b1; dis_win = 3'd1;
        cyc();
        dis_en = 1'b0;
        rd(1, 0);
        chk("R9 staging enable cleared", rd_data, 32'hFE);
        chk("R9 chan cleared", 32'(chan_en), 32'h1D);
        chk("R9 shadow waits", 32'(shd_ctrl[1*CW +: CW]), 32'hFF);
        vs();
        chk("R9 shadow follows", 32'(shd_ctrl[1*CW +: CW]), 32'hFE);

        // R10 clear
        wr(0, 7, 32'h0000_005D);
        clr_en = 1'b1; clr_win = 3'd1;
        cyc();
        clr_en = 1'b0;
        rd(0, 7);
        chk("R10 protect cleared", rd_data, 32'h1D);
        rd(1, 1);
        chk("R10 staging zero", rd_data, 32'h0);
        chk("R10 shadow zero", 32'(shd_tl[1*2*XW +: 2*XW]), 32'h0);

        // R12 codes and index range
        wr(6, 0, 32'h0000_0077);
        rd(6, 0);
        chk("R12 out-of-range read", rd_data, 32'h0);
        wr(4, 6, 32'hDEAD_BEEF);
        rd(4, 6);
        chk("R12 key value code", rd_data, 32'hDEAD_BEEF);

        // random mix against the model
        for (int n = 0; n < 4000; n++) begin
            vsync   = ($urandom_range(0, 7) == 0);
            wr_en   = ($urandom_range(0, 1) == 1);
            wr_win  = 3'($urandom_range(0, 6));
            wr_sel  = 3'($urandom_range(0, 7));
            wr_data = $urandom;
            dis_en  = ($urandom_range(0, 15) == 0);
            dis_win = 3'($urandom_range(0, 5));
            clr_en  = ($urandom_range(0, 31) == 0);
            clr_win = 3'($urandom_range(0, 5));
            rd_win  = 3'($urandom_range(0, 6));
            rd_sel  = 3'($urandom_range(0, 7));
            cyc();
        end
        vsync = 1'b0; wr_en = 1'b0; dis_en = 1'b0; clr_en = 1'b0;
        cyc();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule